// File: doc/BRIEF.md
# Low-Power Entry Checker for a High-Speed Serial Lane

This block sits beside the receiver of one differential data lane that switches between a low-power signalling mode and a high-speed burst mode. A fast sample clock drives it. It watches the two single-ended low-power line levels and an indication that high-speed activity has begun. To enter a burst, the lane must leave the stop level (both lines high), drop the positive line while the negative line stays high, and then drop both lines. Only then may high-speed activity start. The block times the two low plateaus of that entry. It decides whether a downstream receiver could have seen a proper start of transmission.

The three inputs are first synchronised through two flops and then debounced: a level must stay unchanged for a programmable number of samples before the checker accepts it. A state machine follows the accepted levels through the states WAIT (looking for stop), STOP (lane idle high), REQ (positive low, negative high), BRIDGE (both low) and BURST (high-speed running). The transitions are:

- WAIT to STOP on stop.
- STOP to REQ on the positive-low level.
- STOP to BRIDGE on both-low. This is the collapsed entry.
- STOP to BURST on high-speed activity. The entry is missed.
- REQ to BRIDGE on both-low.
- REQ to BURST on high-speed activity. The entry is missed.
- BRIDGE to BURST on high-speed activity. This is the verdict.
- REQ or BRIDGE to WAIT on any level out of order. STOP to WAIT on the negative-low level.
- BURST to STOP on a return to stop.

At each verdict the block pulses either a good-entry output or a missed-entry output. It latches both plateau widths and bumps one of two saturating event counters. A missed entry stands for a dropped frame.

Top module: `sot_entry_monitor`

## Requirements
- R1: Each input passes through a two-flop synchroniser. A level held for fewer than `cfg_stable`+2 samples is never accepted, so a one-sample positive-low step between stop and both-low counts as absent.
- R2: The order stop, positive-low (`lane_p`=0, `lane_n`=1), both-low, then high-speed (`hs_seen`=1) pulses `sot_ok` high for one cycle when the two plateaus together last at least the effective minimum.
- R3: A full-order entry whose plateaus together last fewer samples than the effective minimum pulses `sot_miss` instead of `sot_ok`. The boundary is exact: a sum equal to the minimum passes.
- R4: Going from stop to both-low with no accepted positive-low step, then to high-speed, pulses `sot_miss` and reports a positive-low width of 0.
- R5: High-speed activity accepted while in stop or in the positive-low step (no both-low plateau) pulses `sot_miss`. The widths reached so far are reported, and an unreached plateau is reported as 0.
- R6: `width_lp01` and `width_lp00` are updated on the verdict cycle with the plateau lengths counted in samples, equal to how long each level was held at the pins. They hold their values until the next verdict.
- R7: Any other level order (for example the negative-low level during the entry) returns the checker to waiting for stop. It pulses nothing and leaves the widths unchanged.
- R8: `cfg_min_plateau`=0 selects the default minimum, computed as ceil(MIN_NS·1000/SAMPLE_PS) samples (10 at the default parameters). Any other value is used as the minimum directly.
- R9: `ok_count` and `miss_count` rise by one per verdict of their kind and stop at all ones.
- R10: `cnt_clr` zeroes both counters on the next edge and takes priority over a simultaneous increment.
- R11: After reset, both pulses and both widths are 0 and both counters are 0. `sot_ok` and `sot_miss` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_p | input | 1 | Positive line low-power level (1 = high) |
| lane_n | input | 1 | Negative line low-power level (1 = high) |
| hs_seen | input | 1 | High-speed activity indication from the analog front end |
| cfg_stable | input | FW | Extra samples a level must hold before acceptance |
| cfg_min_plateau | input | CW | Minimum combined plateau in samples, 0 = default |
| cnt_clr | input | 1 | Synchronous clear of both event counters |
| sot_ok | output | 1 | One-cycle pulse: valid entry |
| sot_miss | output | 1 | One-cycle pulse: missed entry (dropped frame) |
| width_lp01 | output | CW | Latched positive-low plateau length in samples |
| width_lp00 | output | CW | Latched both-low plateau length in samples |
| ok_count | output | EW | Saturating count of valid entries |
| miss_count | output | EW | Saturating count of missed entries |

## Verification
The bench aims at the minimum boundary from both sides: a sum exactly equal to the minimum must pass, and a sum one sample short must fail. A design with an off-by-one compare or an off-by-one plateau counter gets one of these two wrong. It also tests the collapsed entry two ways: with the positive-low step left out, and with that step held for only one sample so that the debouncer has to swallow it. A checker that skips the debounce, or that keys only on both-low, would wrongly report a valid entry there. An out-of-order entry must leave the previously latched widths alone. A narrow counter must stop at all ones, and a clear held during a missed entry must win over that increment.

// File: rtl/sot_pkg.sv
package sot_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_STOP   = 3'd1,
        ST_REQ    = 3'd2,
        ST_BRIDGE = 3'd3,
        ST_BURST  = 3'd4
    } sot_state_t;

    // symbol = {hs, p, n}
    localparam logic [1:0] LV_STOP = 2'b11;
    localparam logic [1:0] LV_PLOW = 2'b01;
    localparam logic [1:0] LV_BOTH = 2'b00;

endpackage

// File: rtl/sot_lane_filter.sv
module sot_lane_filter #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lane_p,
    input  logic          lane_n,
    input  logic          hs_in,
    input  logic [FW-1:0] cfg_stable,
    output logic [2:0]    sym_o
);

    logic [2:0]    meta_q;
    logic [2:0]    sync_q;
    logic [2:0]    prev_q;
    logic [FW-1:0] run_q;
    logic [2:0]    filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 3'b000;
            sync_q <= 3'b000;
            prev_q <= 3'b000;
            run_q  <= '0;
            filt_q <= 3'b000;
        end else begin
            meta_q <= {hs_in, lane_p, lane_n};
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (sync_q != prev_q) begin
                run_q <= '0;
            end else if (run_q != {FW{1'b1}}) begin
                run_q <= run_q + 1'b1;
            end
            if ((sync_q == prev_q) && (run_q >= cfg_stable)) begin
                filt_q <= sync_q;
            end
        end
    end

    assign sym_o = filt_q;

    // R1: an accepted level change only follows a full stable run
    p_accept_after_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(run_q) >= $past(cfg_stable)));

endmodule

// File: rtl/sot_sat_counter.sv
module sot_sat_counter #(
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [EW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && (q != {EW{1'b1}})) begin
            q <= q + 1'b1;
        end
    end

    p_hold_at_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((q == {EW{1'b1}}) && !clr) |=> (q == {EW{1'b1}}));

    p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q == $past(q)) || (q == $past(q) + 1'b1)));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

endmodule

// File: rtl/sot_entry_fsm.sv
module sot_entry_fsm
    import sot_pkg::*;
#(
    parameter int          CW      = 12,
    parameter logic [CW-1:0] DEF_MIN = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sym,
    input  logic [CW-1:0] min_cfg,
    output logic          ok_o,
    output logic          miss_o,
    output logic [CW-1:0] w01_o,
    output logic [CW-1:0] w00_o
);

    sot_state_t    state_q, state_n;
    logic [CW-1:0] c01_q, c01_n;
    logic [CW-1:0] c00_q, c00_n;
    logic          skip_q, skip_n;
    logic          hit_ok, hit_miss;
    logic [CW-1:0] eff_min;
    logic [CW:0]   plateau_sum;
    logic          is_hs;
    logic [1:0]    lv;

    assign is_hs       = sym[2];
    assign lv          = sym[1:0];
    assign eff_min     = (min_cfg == '0) ? DEF_MIN : min_cfg;
    assign plateau_sum = {1'b0, c01_q} + {1'b0, c00_q};

    always_comb begin
        state_n  = state_q;
        c01_n    = c01_q;
        c00_n    = c00_q;
        skip_n   = skip_q;
        hit_ok   = 1'b0;
        hit_miss = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (!is_hs && lv == LV_STOP) state_n = ST_STOP;
            end
            ST_STOP: begin
                if (is_hs) begin
                    hit_miss = 1'b1;
                    c01_n    = '0;
                    c00_n    = '0;
                    state_n  = ST_BURST;
                end else if (lv == LV_PLOW) begin
                    c01_n   = {{(CW-1){1'b0}}, 1'b1};
                    skip_n  = 1'b0;
                    state_n = ST_REQ;
                end else if (lv == LV_BOTH) begin
                    c01_n   = '0;
                    c00_n   = {{(CW-1){1'b0}}, 1'b1};
                    skip_n  = 1'b1;
                    state_n = ST_BRIDGE;
                end else if (lv != LV_STOP) begin
                    state_n = ST_WAIT;
                end
            end
            ST_REQ: begin
                if (is_hs) begin
                    hit_miss = 1'b1;
                    c00_n    = '0;
                    state_n  = ST_BURST;
                end else if (lv == LV_PLOW) begin
                    if (c01_q != {CW{1'b1}}) c01_n = c01_q + 1'b1;
                end else if (lv == LV_BOTH) begin
                    c00_n   = {{(CW-1){1'b0}}, 1'b1};
                    state_n = ST_BRIDGE;
                end else begin
                    state_n = ST_WAIT;
                end
            end
            ST_BRIDGE: begin
                if (is_hs) begin
                    if (skip_q || (plateau_sum < {1'b0, eff_min})) hit_miss = 1'b1;
                    else                                           hit_ok   = 1'b1;
                    state_n = ST_BURST;
                end else if (lv == LV_BOTH) begin
                    if (c00_q != {CW{1'b1}}) c00_n = c00_q + 1'b1;
                end else begin
                    state_n = ST_WAIT;
                end
            end
            ST_BURST: begin
                if (!is_hs && lv == LV_STOP) state_n = ST_STOP;
            end
            default: state_n = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            c01_q   <= '0;
            c00_q   <= '0;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            c01_q   <= c01_n;
            c00_q   <= c00_n;
            skip_q  <= skip_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_o   <= 1'b0;
            miss_o <= 1'b0;
            w01_o  <= '0;
            w00_o  <= '0;
        end else begin
            ok_o   <= hit_ok;
            miss_o <= hit_miss;
            if (hit_ok || hit_miss) begin
                w01_o <= c01_n;
                w00_o <= c00_n;
            end
        end
    end

    p_verdicts_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && miss_o));

    p_ok_has_both_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> ((w01_o != '0) && (w00_o != '0)));

    p_ok_meets_minimum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> (({1'b0, w01_o} + {1'b0, w00_o}) >= {1'b0, $past(eff_min)}));

    p_ok_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |=> !ok_o);

    p_widths_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o || miss_o) |-> ($stable(w01_o) && $stable(w00_o)));

endmodule

// File: rtl/sot_entry_monitor.sv
module sot_entry_monitor #(
    parameter int SAMPLE_PS = 5000,
    parameter int MIN_NS    = 50,
    parameter int CW        = 12,
    parameter int FW        = 4,
    parameter int EW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lane_p,
    input  logic          lane_n,
    input  logic          hs_seen,
    input  logic [FW-1:0] cfg_stable,
    input  logic [CW-1:0] cfg_min_plateau,
    input  logic          cnt_clr,
    output logic          sot_ok,
    output logic          sot_miss,
    output logic [CW-1:0] width_lp01,
    output logic [CW-1:0] width_lp00,
    output logic [EW-1:0] ok_count,
    output logic [EW-1:0] miss_count
);

    localparam int            DEF_TICKS = (MIN_NS * 1000 + SAMPLE_PS - 1) / SAMPLE_PS;
    localparam logic [CW-1:0] DEF_MIN   = CW'(DEF_TICKS);
    localparam int            NCNT      = 2;

    logic [2:0]    sym;
    logic [NCNT-1:0] bump;
    logic [EW-1:0] cnt_q [NCNT];

    sot_lane_filter #(.FW(FW)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_p     (lane_p),
        .lane_n     (lane_n),
        .hs_in      (hs_seen),
        .cfg_stable (cfg_stable),
        .sym_o      (sym)
    );

    sot_entry_fsm #(.CW(CW), .DEF_MIN(DEF_MIN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym     (sym),
        .min_cfg (cfg_min_plateau),
        .ok_o    (sot_ok),
        .miss_o  (sot_miss),
        .w01_o   (width_lp01),
        .w00_o   (width_lp00)
    );

    assign bump = {sot_miss, sot_ok};

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        sot_sat_counter #(.EW(EW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (bump[g]),
            .q     (cnt_q[g])
        );
    end

    assign ok_count   = cnt_q[0];
    assign miss_count = cnt_q[1];

endmodule

// File: tb/sot_entry_monitor_tb.sv
module sot_entry_monitor_tb;

    localparam int CW = 12;
    localparam int FW = 4;
    localparam int EW = 3;
    localparam int NV = 10;

    // per entry: positive-low length, both-low length, insert negative-low step,
    // minimum setting, expected ok pulses, expected miss pulses, expected widths
    localparam int T_D01 [NV] = '{6, 5, 4, 4,  0,  1, 7, 0, 5, 4};
    localparam int T_D00 [NV] = '{8, 6, 6, 5, 12, 12, 0, 0, 5, 5};
    localparam int T_ODD [NV] = '{0, 1, 0, 0,  0,  0, 0, 0, 0, 0};
    localparam int T_MIN [NV] = '{10,10,10,10, 5,  5, 5, 5, 0, 0};
    localparam int T_OK  [NV] = '{1, 0, 1, 0,  0,  0, 0, 0, 1, 0};
    localparam int T_MS  [NV] = '{0, 0, 0, 1,  1,  1, 1, 1, 0, 1};
    localparam int T_W01 [NV] = '{6, 6, 4, 4,  0,  0, 7, 0, 5, 4};
    localparam int T_W00 [NV] = '{8, 8, 6, 5, 12, 12, 0, 0, 5, 5};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lane_p = 1'b1;
    logic          lane_n = 1'b1;
    logic          hs_seen = 1'b0;
    logic [FW-1:0] cfg_stable = FW'(2);
    logic [CW-1:0] cfg_min_plateau = '0;
    logic          cnt_clr = 1'b0;
    logic          sot_ok, sot_miss;
    logic [CW-1:0] width_lp01, width_lp00;
    logic [EW-1:0] ok_count, miss_count;

    int n_tests = 0;
    int n_fail  = 0;
    int n_ok    = 0;
    int n_miss  = 0;
    int n_both  = 0;

    always #5 clk = ~clk;

    sot_entry_monitor #(.CW(CW), .FW(FW), .EW(EW)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .lane_p          (lane_p),
        .lane_n          (lane_n),
        .hs_seen         (hs_seen),
        .cfg_stable      (cfg_stable),
        .cfg_min_plateau (cfg_min_plateau),
        .cnt_clr         (cnt_clr),
        .sot_ok          (sot_ok),
        .sot_miss        (sot_miss),
        .width_lp01      (width_lp01),
        .width_lp00      (width_lp00),
        .ok_count        (ok_count),
        .miss_count      (miss_count)
    );

    always @(negedge clk) begin
        if (sot_ok)             n_ok++;
        if (sot_miss)           n_miss++;
        if (sot_ok && sot_miss) n_both++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic hs, input logic p, input logic n, input int cyc);
        hs_seen = hs;
        lane_p  = p;
        lane_n  = n;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic entry(input int d01, input int d00, input int odd, input int mn);
        cfg_min_plateau = CW'(mn);
        n_ok   = 0;
        n_miss = 0;
        put(1'b0, 1'b1, 1'b1, 8);
        if (d01 > 0) put(1'b0, 1'b0, 1'b1, d01);
        if (odd > 0) put(1'b0, 1'b1, 1'b0, 4);
        if (d00 > 0) put(1'b0, 1'b0, 1'b0, d00);
        put(1'b1, 1'b0, 1'b0, 10);
        put(1'b0, 1'b1, 1'b1, 12);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 ok after reset",    int'(sot_ok), 0);
        chk("R11 miss after reset",  int'(sot_miss), 0);
        chk("R11 w01 after reset",   int'(width_lp01), 0);
        chk("R11 w00 after reset",   int'(width_lp00), 0);
        chk("R11 okcnt after reset", int'(ok_count), 0);
        chk("R11 mscnt after reset", int'(miss_count), 0);

        // table: R2 R3 R4 R5 R6 R7 R8 R1
        for (int i = 0; i < NV; i++) begin
            entry(T_D01[i], T_D00[i], T_ODD[i], T_MIN[i]);
            chk($sformatf("R2/R3/R8 ok pulses entry %0d", i),   n_ok,   T_OK[i]);
            chk($sformatf("R3/R4/R5/R7 miss pulses entry %0d", i), n_miss, T_MS[i]);
            chk($sformatf("R6/R1 width_lp01 entry %0d", i), int'(width_lp01), T_W01[i]);
            chk($sformatf("R6 width_lp00 entry %0d", i),    int'(width_lp00), T_W00[i]);
        end

        chk("R9 ok_count after table",   int'(ok_count), 3);
        chk("R9 miss_count after table", int'(miss_count), 6);

        // R9: saturation at all ones (3-bit counter)
        entry(0, 0, 0, 5);
        chk("R9 miss_count reaches top", int'(miss_count), 7);
        entry(0, 0, 0, 5);
        chk("R9 miss_count held at top", int'(miss_count), 7);
        chk("R5 miss pulse on direct high-speed", n_miss, 1);

        // R10: clear held across a missed entry wins over its increment
        cnt_clr = 1'b1;
        entry(0, 0, 0, 5);
        cnt_clr = 1'b0;
        @(negedge clk);
        chk("R10 miss_count cleared", int'(miss_count), 0);
        chk("R10 ok_count cleared",   int'(ok_count), 0);

        // R2 after clear: counter resumes
        entry(6, 6, 0, 10);
        chk("R2 ok pulse after clear", n_ok, 1);
        chk("R9 ok_count after clear", int'(ok_count), 1);

        chk("R11 pulses never together", n_both, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule